// File: doc/BRIEF.md
# Dual-Modulus Fractional Clock-Enable Divider

This block turns a fast reference clock into a slower train of single-cycle enable pulses. The pulse rate need not be an integer fraction of the reference. The block uses two integer divisors in turn. It runs a first group of output periods at the first divisor, then a second group at the second divisor, and repeats this pattern. The average division ratio is `(A0*R0 + A1*R1)/(R0 + R1)`. Here A0 and A1 are the two divisors, and R0 and R1 are the repeat counts of the two groups.

Software sets the block up through two 32-bit registers, written over a simple write-only port. The divisor fields, the repeat-count fields, a run gate and a 2-bit output mode all live in these registers. Every field stores its value minus one.

With the default reference of 24 MHz, a typical setting gives an average ratio of 732.4, which is 32768 Hz. That setting is divisor fields 0x2DC and 0x2DB with repeat fields 1 and 2, meaning divisors 733/732 and repeats 2/3.

Top module: `frac_clk_div`

## Requirements
- R1: After reset both registers read as zero internally, so the gate is off and `tickOut` is low until software programs the block.
- R2: A write with `wrAddr` = 0x28 loads the divisor register and a write with `wrAddr` = 0x2C loads the repeat register; a write to any other address changes nothing and does not disturb the running pulse train.
- R3: Divisor register layout: bits 11:0 hold the first divisor field, bits 23:12 the second divisor field, bits 29:28 the output mode, bit 31 the run gate.
- R4: Repeat register layout: bits 11:0 hold the first repeat field and bits 23:12 the second repeat field.
- R5: Every field encodes its value minus one: a divisor field D gives periods of D+1 reference cycles (D = 0 gives a pulse on every cycle), and a repeat field R gives R+1 periods.
- R6: The pulse train consists of (first repeat) periods of (first divisor) cycles, then (second repeat) periods of (second divisor) cycles, then repeats from the first group.
- R7: `tickOut` is high for exactly one reference cycle per period; the first pulse after a register write appears on the edge that is first-divisor cycles after the write edge.
- R8: While the run gate is 0 all counters are held cleared and no pulse is produced.
- R9: With the gate set, an output mode other than 1 keeps `tickOut` low.
- R10: Any write to either register restarts the sequence at the beginning of the first-divisor group.
- R11: With fields 0x2DC/0x2DB/1/2, exactly 10 pulses fall in the 7324 cycles after the write, which is an average ratio of 732.4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrAddr | input | 8 | Byte address of the register written |
| wrData | input | 32 | Write data |
| tickOut | output | 1 | One-cycle enable pulse per generated period |

## Verification
The bench runs the divider with the following settings:
- Unequal small divisors and repeat counts, which show that the group order and the group lengths are both right.
- Divisor fields of zero, which separate a divide-by-one pulse on every cycle from an off-by-one in the minus-one decode.
- The 24 MHz setting, measured over two full patterns, which confirms the fractional average.

Further runs target control behaviour:
- Writes to a stray address in the middle of a run must leave the pulse phase unchanged.
- A write to the repeat register in the middle of a period must restart the first group, which separates a true restart from a plain register update.
- Gate-off and mode-other-than-one runs must stay silent.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

  // Strobes sent from the sequencing control to the period datapath.
  typedef struct packed {
    logic clear;   // force the period counter to zero
    logic run;     // let the period counter advance
    logic selN1;   // use the second divisor limit
  } divStrobe_t;

  localparam int MODE_W   = 2;
  localparam logic [MODE_W-1:0] MODE_DIVIDED = 2'd1;

endpackage

// File: rtl/fdiv_datapath.sv
module fdiv_datapath
  import fdiv_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  divStrobe_t       strobe,
  input  logic [CNT_W-1:0] n0Lim,
  input  logic [CNT_W-1:0] n1Lim,
  output logic             periodEnd
);

  logic [CNT_W-1:0] divCnt;
  logic [CNT_W-1:0] limit;

  // The limit is the stored field, i.e. divisor minus one.
  assign limit     = strobe.selN1 ? n1Lim : n0Lim;
  assign periodEnd = strobe.run && (divCnt == limit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (strobe.clear) begin
      divCnt <= '0;
    end else if (strobe.run) begin
      if (periodEnd) divCnt <= '0;
      else           divCnt <= divCnt + 1'b1;
    end
  end

  // R5: counter never passes the active divisor limit
  p_cnt_within_limit_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.run |-> (divCnt <= limit));

  // R8: a clear request leaves the counter at zero
  p_clear_zeroes_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (divCnt == '0));

endmodule

// File: rtl/fdiv_ctrl.sv
module fdiv_ctrl
  import fdiv_pkg::*;
#(
  parameter int              DATA_W    = 32,
  parameter int              CNT_W     = 12,
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              periodEnd,
  output divStrobe_t        strobe,
  output logic [CNT_W-1:0]  n0Lim,
  output logic [CNT_W-1:0]  n1Lim,
  output logic              tickOut
);

  localparam int NUM_REGS = 2;
  localparam int STRIDE   = 4;
  localparam int LO_LSB   = 0;
  localparam int HI_LSB   = CNT_W;
  localparam int GATE_BIT = DATA_W - 1;
  localparam int MODE_LSB = DATA_W - 4;

  logic [DATA_W-1:0]   cfgReg [NUM_REGS];
  logic [NUM_REGS-1:0] hitVec;
  logic                restart;
  logic                gateOn;
  logic                modeOn;
  logic [CNT_W-1:0]    m0Lim;
  logic [CNT_W-1:0]    m1Lim;
  logic [CNT_W-1:0]    repLim;
  logic [CNT_W-1:0]    repCnt;
  logic                phase;

  // Register bank: one decoded register per word offset.
  for (genvar g = 0; g < NUM_REGS; g++) begin : gRegs
    assign hitVec[g] = wrEn && (wrAddr == ADDR_W'(BASE_ADDR + STRIDE * g));
    always_ff @(posedge clk) begin
      if (!rstN)          cfgReg[g] <= '0;
      else if (hitVec[g]) cfgReg[g] <= wrData;
    end
  end

  assign restart = |hitVec;
  assign gateOn  = cfgReg[0][GATE_BIT];
  assign modeOn  = (cfgReg[0][MODE_LSB +: MODE_W] == MODE_DIVIDED);
  assign n0Lim   = cfgReg[0][LO_LSB +: CNT_W];
  assign n1Lim   = cfgReg[0][HI_LSB +: CNT_W];
  assign m0Lim   = cfgReg[1][LO_LSB +: CNT_W];
  assign m1Lim   = cfgReg[1][HI_LSB +: CNT_W];
  assign repLim  = phase ? m1Lim : m0Lim;

  always_comb begin
    strobe.clear = restart || !gateOn;
    strobe.run   = gateOn && !restart;
    strobe.selN1 = phase;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= 1'b0;
      repCnt  <= '0;
      tickOut <= 1'b0;
    end else if (strobe.clear) begin
      phase   <= 1'b0;
      repCnt  <= '0;
      tickOut <= 1'b0;
    end else begin
      tickOut <= periodEnd && modeOn;
      if (periodEnd) begin
        if (repCnt == repLim) begin
          repCnt <= '0;
          phase  <= ~phase;
        end else begin
          repCnt <= repCnt + 1'b1;
        end
      end
    end
  end

  // R8: gate off means no pulse on the following cycle
  p_gate_off_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !gateOn |=> !tickOut);

  // R9: a pulse only follows a cycle in divided-output mode
  p_mode_gates_tick_r9: assert property (@(posedge clk) disable iff (!rstN)
    tickOut |-> $past(modeOn));

  // R10: a register write returns the sequence to the first group
  p_restart_phase0_r10: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (!phase && repCnt == '0));

  // R6: repeat counter stays inside the active group length
  p_rep_bounded_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.run |-> (repCnt <= repLim));

endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import fdiv_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter int                CNT_W     = 12,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              tickOut
);

  divStrobe_t       strobe;
  logic [CNT_W-1:0] n0Lim;
  logic [CNT_W-1:0] n1Lim;
  logic             periodEnd;

  fdiv_ctrl #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .periodEnd(periodEnd), .strobe(strobe), .n0Lim(n0Lim), .n1Lim(n1Lim),
    .tickOut(tickOut)
  );

  fdiv_datapath #(
    .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .n0Lim(n0Lim), .n1Lim(n1Lim),
    .periodEnd(periodEnd)
  );

endmodule

// File: tb/frac_clk_div_tb.sv
module frac_clk_div_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        tickOut;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  string curReq = "R1";
  bit modelArmed = 1'b0;

  // behavioural reference state
  logic [31:0] mR0 = '0, mR1 = '0;
  int  elapsed = 0, pIdx = 0;
  bit  expTick = 1'b0;

  always #2.5 clk = ~clk;

  frac_clk_div dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .tickOut(tickOut)
  );

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
      finishRun();
    end
  end

  // Reference: period length chosen by position in the full pattern.
  always @(posedge clk) begin
    int n0, n1, m0, m1, curN;
    if (!rstN) begin
      mR0 = '0; mR1 = '0; elapsed = 0; pIdx = 0; expTick = 1'b0;
    end else if (wrEn && (wrAddr == 8'h28 || wrAddr == 8'h2C)) begin
      if (wrAddr == 8'h28) mR0 = wrData; else mR1 = wrData;
      elapsed = 0; pIdx = 0; expTick = 1'b0;
    end else if (mR0[31]) begin
      n0 = int'(mR0[11:0]) + 1;  n1 = int'(mR0[23:12]) + 1;
      m0 = int'(mR1[11:0]) + 1;  m1 = int'(mR1[23:12]) + 1;
      curN = (pIdx < m0) ? n0 : n1;
      elapsed++;
      if (elapsed == curN) begin
        expTick = (mR0[29:28] == 2'd1);
        elapsed = 0;
        pIdx++;
        if (pIdx == m0 + m1) pIdx = 0;
      end else begin
        expTick = 1'b0;
      end
    end else begin
      elapsed = 0; pIdx = 0; expTick = 1'b0;
    end
  end

  // Compare on every cycle, away from the active edge.
  always @(negedge clk) begin
    if (modelArmed) begin
      compared++;
      if (tickOut !== expTick) begin
        mismatched++;
        $display("FAIL %s cycle %0d: tickOut actual=%b expected=%b",
                 curReq, cycles, tickOut, expTick);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Counts pulses over n negedges following the current point.
  task automatic countTicks(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tickOut) cnt++;
    end
  endtask

  // Returns the number of negedges until the first pulse (0 if none in lim).
  task automatic firstTick(input int lim, output int at);
    at = 0;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (tickOut && at == 0) at = i;
    end
  endtask

  initial begin
    int cnt, at;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 tick low after reset", int'(tickOut), 0);
    modelArmed = 1'b1;
    countTicks(40, cnt);
    check("R1 silent while unprogrammed", cnt, 0);

    // R3 R4 R5 R6 R7: divisors 3/5, repeats 2/1
    curReq = "R6";
    writeReg(8'h2C, {8'h0, 12'd0, 12'd1});
    writeReg(8'h28, {1'b1, 1'b0, 2'd1, 4'h0, 12'd4, 12'd2});
    // write edge was just before the last negedge: first pulse after 3 edges
    firstTick(3, at);
    check("R7 first pulse after first divisor", at, 3);
    // remainder of pattern: periods 3,5 then 3,3,5 -> in 5+11 cycles 1+3 pulses
    countTicks(16, cnt);
    check("R6 pulses in following pattern", cnt, 4);
    countTicks(200, cnt);

    // R2: stray address does not disturb
    curReq = "R2";
    writeReg(8'h30, 32'hFFFF_FFFF);
    writeReg(8'h24, 32'h0);
    countTicks(60, cnt);
    check("R2 stray writes keep pulse rate", cnt, 60 * 3 / 11 + ((cnt > 60 * 3 / 11) ? 1 : 0));

    // R10: repeat-register write mid-period restarts first group
    curReq = "R10";
    @(negedge clk);
    writeReg(8'h2C, {8'h0, 12'd2, 12'd0});
    firstTick(3, at);
    check("R10 restart gives first divisor period", at, 3);
    countTicks(150, cnt);

    // R5: zero divisor fields give a pulse every cycle
    curReq = "R5";
    writeReg(8'h28, {1'b1, 1'b0, 2'd1, 4'h0, 12'd0, 12'd0});
    countTicks(20, cnt);
    check("R5 divide-by-one pulses every cycle", cnt, 20);

    // R9: other output modes hold low
    curReq = "R9";
    writeReg(8'h28, {1'b1, 1'b0, 2'd2, 4'h0, 12'd1, 12'd1});
    countTicks(50, cnt);
    check("R9 mode 2 silent", cnt, 0);
    writeReg(8'h28, {1'b1, 1'b0, 2'd0, 4'h0, 12'd1, 12'd1});
    countTicks(30, cnt);
    check("R9 mode 0 silent", cnt, 0);

    // R8: gate off holds everything
    curReq = "R8";
    writeReg(8'h28, {1'b0, 1'b0, 2'd1, 4'h0, 12'd1, 12'd1});
    countTicks(50, cnt);
    check("R8 gate off silent", cnt, 0);

    // R11: 24 MHz to 32768 Hz setting
    curReq = "R11";
    writeReg(8'h2C, {8'h0, 12'd2, 12'd1});
    writeReg(8'h28, {1'b1, 1'b0, 2'd1, 4'h0, 12'h2DB, 12'h2DC});
    countTicks(7324, cnt);
    check("R11 ten pulses per 7324 cycles", cnt, 10);
    countTicks(100, cnt);

    modelArmed = 1'b0;
    finishRun();
  end

endmodule